// File: doc/BRIEF.md
# Windowed Watchdog Timer with Prewarning

This block watches over software by counting up a 16-bit timer that must be serviced before it wraps around. The timer is built from two 8-bit halves: the lower half counts prescaled ticks, and its carry advances the upper half. Each tick comes from a peripheral clock divided by either 2 or 128. A 7-bit divider that runs freely between clears produces the ticks.

A service strobe is accepted only when the upper half of the timer has reached a programmed window boundary. An accepted service loads the upper half from a programmable reload byte and zeroes the lower half. A service that comes too early counts as a failure. So does a wrap of the timer. Either one produces a one-cycle non-maskable interrupt pulse and starts a prewarning phase of fixed length. Nothing can stop the prewarning phase once it has begun. When it ends, the block pulses a reset request and returns to its reset state.

A debug-suspend input freezes all counting while it is high. The enable input gates counting and service.

Top module: `wdog_window`

## Requirements
- R1: A synchronous active-high `rst` drives `count`, `nmi`, `rst_req` and `timeout_flag` to zero.
- R2: With the fast rate selected (`slow_sel`=0 when the divider was last cleared), `count` advances by one every 2 clock cycles while `en`=1 and `dbg_hold`=0. A carry out of the low byte (bits 7:0) increments the high byte (bits 15:8).
- R3: With the slow rate selected (`slow_sel`=1), `count` advances by one every 128 clock cycles.
- R4: An accepted service loads `count` with {`reload_val`, 8'h00} on the next cycle and restarts the divider. A service is accepted when `svc`=1, `en`=1, no prewarning is active, and `count[15:8]` >= `win_bound`.
- R5: A service with `count[15:8]` < `win_bound` is premature. It does not reload `count`. On the next cycle it raises `nmi` and sets `timeout_flag`.
- R6: A tick that arrives while `count` is 16'hFFFF, with no accepted service in that cycle, wraps `count` to 0 and raises `nmi` on the next cycle.
- R7: On the 64th tick after prewarning begins, `rst_req` is high for exactly one cycle. In that same cycle `count` is 0 and `timeout_flag` is 0.
- R8: A service strobe during prewarning has no effect. `count` keeps counting, and the reset request still arrives on schedule.
- R9: While `dbg_hold`=1, `count` and the progress of prewarning hold still.
- R10: While `en`=0, `count` holds, `svc` is ignored and the divider is held cleared.
- R11: A change of `slow_sel` takes effect only when the 7-bit divider wraps from 127 to 0, or when the divider is cleared (reset, `en`=0, accepted service, end of prewarning).
- R12: `nmi` is high for a single cycle per timeout. `timeout_flag` stays high for the whole prewarning phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Watchdog enable |
| svc | input | 1 | Service strobe |
| slow_sel | input | 1 | Rate select: 0 = divide by 2, 1 = divide by 128 |
| dbg_hold | input | 1 | Debug suspend, freezes counting |
| reload_val | input | 8 | High-byte value loaded on an accepted service |
| win_bound | input | 8 | Lowest high-byte value at which a service is legal |
| count | output | 16 | Current timer value |
| nmi | output | 1 | One-cycle non-maskable interrupt at timeout |
| rst_req | output | 1 | One-cycle system reset request at the end of prewarning |
| timeout_flag | output | 1 | High from timeout until the reset request |

## Verification
The assertions assume that every input is synchronous to `clk`. They treat `timeout_flag` as the marker of the prewarning phase. They also assume `reload_val` is sampled in the same cycle as the service strobe, so the bench never relies on the reload byte changing at any other moment. The random stimulus redraws the rate select, enable, debug hold, window and reload values with low probability. It biases the reload byte toward the top of its range so that wraps, premature services and full prewarning phases all occur many times within the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_WARN = 1'b1
  } wd_phase_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV_W    = 7,
  parameter int FAST_LOG = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic slow_sel,
  output logic tick
);
  localparam logic [DIV_W-1:0] DIV_TOP = '1;

  logic [DIV_W-1:0] div_q;
  logic             slow_q;
  logic             fast_edge;
  logic             slow_edge;

  assign fast_edge = &div_q[FAST_LOG-1:0];
  assign slow_edge = (div_q == DIV_TOP);
  assign tick      = step && (slow_q ? slow_edge : fast_edge);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q  <= '0;
      slow_q <= slow_sel;
    end else if (step) begin
      div_q <= div_q + 1'b1;
      if (slow_edge) slow_q <= slow_sel;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 load,
  input  logic                 tick,
  input  logic [HI_W-1:0]      reload,
  output logic [LO_W+HI_W-1:0] value,
  output logic                 full
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            carry;

  assign carry = &lo_q;
  assign full  = carry && (&hi_q);
  assign value = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst || clr)  lo_q <= '0;
    else if (load)   lo_q <= '0;
    else if (tick)   lo_q <= lo_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          hi_q <= '0;
    else if (load)           hi_q <= reload;
    else if (tick && carry)  hi_q <= hi_q + 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int PW_TICKS = 64,
  parameter int HI_W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            svc_req,
  input  logic            full,
  input  logic [HI_W-1:0] hi,
  input  logic [HI_W-1:0] win,
  output logic            load,
  output logic            wrap,
  output logic            nmi,
  output logic            rst_req,
  output logic            flag
);
  localparam int              PW_W    = $clog2(PW_TICKS);
  localparam logic [PW_W-1:0] PW_LAST = PW_W'(PW_TICKS - 1);

  wd_phase_e       phase_q;
  logic [PW_W-1:0] pw_q;
  logic            in_run;
  logic            early;
  logic            expire;

  assign in_run = (phase_q == WD_RUN);
  assign early  = svc_req && in_run && (hi < win);
  assign load   = svc_req && in_run && !(hi < win);
  assign expire = early || (in_run && tick && full && !load);
  assign wrap   = !in_run && tick && (pw_q == PW_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= WD_RUN;
      pw_q    <= '0;
      nmi     <= 1'b0;
      rst_req <= 1'b0;
      flag    <= 1'b0;
    end else begin
      nmi     <= expire;
      rst_req <= wrap;
      if (expire) begin
        phase_q <= WD_WARN;
        pw_q    <= '0;
        flag    <= 1'b1;
      end else if (wrap) begin
        phase_q <= WD_RUN;
        pw_q    <= '0;
        flag    <= 1'b0;
      end else if (!in_run && tick) begin
        pw_q <= pw_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int LO_W     = 8,
  parameter int HI_W     = 8,
  parameter int DIV_W    = 7,
  parameter int FAST_LOG = 1,
  parameter int PW_TICKS = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 svc,
  input  logic                 slow_sel,
  input  logic                 dbg_hold,
  input  logic [HI_W-1:0]      reload_val,
  input  logic [HI_W-1:0]      win_bound,
  output logic [LO_W+HI_W-1:0] count,
  output logic                 nmi,
  output logic                 rst_req,
  output logic                 timeout_flag
);
  localparam int CNT_W = LO_W + HI_W;

  logic step;
  logic svc_req;
  logic tick;
  logic load;
  logic wrap;
  logic full;
  logic div_clr;

  assign step    = en && !dbg_hold;
  assign svc_req = svc && en;
  assign div_clr = !en || load || wrap;

  wdog_prescale #(
    .DIV_W    (DIV_W),
    .FAST_LOG (FAST_LOG)
  ) u_prescale (
    .clk      (clk),
    .rst      (rst),
    .clr      (div_clr),
    .step     (step),
    .slow_sel (slow_sel),
    .tick     (tick)
  );

  wdog_count #(
    .LO_W (LO_W),
    .HI_W (HI_W)
  ) u_count (
    .clk    (clk),
    .rst    (rst),
    .clr    (wrap),
    .load   (load),
    .tick   (tick),
    .reload (reload_val),
    .value  (count),
    .full   (full)
  );

  wdog_ctrl #(
    .PW_TICKS (PW_TICKS),
    .HI_W     (HI_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .svc_req (svc_req),
    .full    (full),
    .hi      (count[CNT_W-1:LO_W]),
    .win     (win_bound),
    .load    (load),
    .wrap    (wrap),
    .nmi     (nmi),
    .rst_req (rst_req),
    .flag    (timeout_flag)
  );
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 svc,
  input logic                 dbg_hold,
  input logic [HI_W-1:0]      reload_val,
  input logic [HI_W-1:0]      win_bound,
  input logic [LO_W+HI_W-1:0] count,
  input logic                 nmi,
  input logic                 rst_req,
  input logic                 timeout_flag
);
  localparam int CNT_W = LO_W + HI_W;

  p_nmi_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    nmi |=> !nmi);

  p_rr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_rr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (count == '0) && !timeout_flag);

  p_nmi_flag_r5: assert property (@(posedge clk) disable iff (rst)
    nmi |-> timeout_flag);

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (svc && en && !timeout_flag && (count[CNT_W-1:LO_W] >= win_bound))
    |=> (count == {$past(reload_val), {LO_W{1'b0}}}));

  p_early_r5: assert property (@(posedge clk) disable iff (rst)
    (svc && en && !timeout_flag && (count[CNT_W-1:LO_W] < win_bound))
    |=> (nmi && timeout_flag));

  p_hold_dbg_r9: assert property (@(posedge clk) disable iff (rst)
    (dbg_hold && !svc) |=> $stable(count));

  p_hold_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));
endmodule

bind wdog_window wdog_window_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/wdog_window_bench.sv
`timescale 1ns/1ps
module wdog_window_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic        svc;
  logic        slow_sel;
  logic        dbg_hold;
  logic [7:0]  reload_val;
  logic [7:0]  win_bound;
  logic [15:0] count;
  logic        nmi;
  logic        rst_req;
  logic        timeout_flag;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [6:0]  m_div;
  bit          m_sel;
  logic [15:0] m_cnt;
  bit          m_warn;
  int          m_pw;
  bit          m_nmi, m_rr, m_flag;

  always #2 clk = ~clk;

  wdog_window u_wdog_window (
    .clk(clk), .rst(rst), .en(en), .svc(svc), .slow_sel(slow_sel),
    .dbg_hold(dbg_hold), .reload_val(reload_val), .win_bound(win_bound),
    .count(count), .nmi(nmi), .rst_req(rst_req), .timeout_flag(timeout_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Requirement model: next state from the inputs present before the edge.
  task automatic model_next();
    bit stp, tk, sv, ok, pre, fin;
    logic [7:0] hi;
    if (rst) begin
      m_div = '0; m_sel = slow_sel; m_cnt = '0; m_warn = 0; m_pw = 0;
      m_nmi = 0; m_rr = 0; m_flag = 0;
      return;
    end
    stp = en && !dbg_hold;
    tk  = stp && (m_sel ? (m_div == 7'd127) : m_div[0]);
    hi  = m_cnt[15:8];
    sv  = svc && en && !m_warn;
    ok  = sv && (hi >= win_bound);
    pre = sv && (hi < win_bound);
    fin = m_warn && tk && (m_pw == 63);
    m_nmi = pre || (!m_warn && tk && (m_cnt == 16'hFFFF) && !ok);
    m_rr  = fin;
    if (fin)      m_cnt = '0;
    else if (ok)  m_cnt = {reload_val, 8'h00};
    else if (tk)  m_cnt = m_cnt + 16'd1;
    if (!en || ok || fin) begin
      m_div = '0; m_sel = slow_sel;
    end else if (stp) begin
      if (m_div == 7'd127) m_sel = slow_sel;
      m_div = m_div + 7'd1;
    end
    if (m_nmi) begin
      m_warn = 1; m_pw = 0; m_flag = 1;
    end else if (fin) begin
      m_warn = 0; m_pw = 0; m_flag = 0;
    end else if (m_warn && tk) begin
      m_pw++;
    end
  endtask

  task automatic cyc();
    model_next();
    @(posedge clk);
    #1;
    chk(count === m_cnt, "R2 count", count, m_cnt);
    chk(nmi === m_nmi, "R6 nmi", nmi, m_nmi);
    chk(rst_req === m_rr, "R7 rst_req", rst_req, m_rr);
    chk(timeout_flag === m_flag, "R12 timeout_flag", timeout_flag, m_flag);
  endtask

  task automatic cycn(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    rst = 1; en = 0; svc = 0; slow_sel = 0; dbg_hold = 0;
    reload_val = 8'h00; win_bound = 8'h00;
    #1;
    cycn(3);
    // R1 reset state
    chk(count == 16'h0 && !nmi && !rst_req && !timeout_flag, "R1 reset", {count, 3'b0, nmi, rst_req, timeout_flag}, 0);
    rst = 0; en = 1;
    cycn(20);
    chk(count == 16'd10, "R2 fast rate", count, 10);
    en = 0;
    cycn(10);
    chk(count == 16'd10, "R10 disabled hold", count, 10);
    en = 1; dbg_hold = 1;
    cycn(10);
    chk(count == 16'd10, "R9 debug hold", count, 10);
    dbg_hold = 0;
    svc = 1; reload_val = 8'h10;
    cyc();
    svc = 0;
    chk(count == 16'h1000, "R4 accepted service", count, 16'h1000);
    slow_sel = 1;
    cycn(128);
    chk(count == 16'h1040, "R11 old rate until wrap", count, 16'h1040);
    cycn(128);
    chk(count == 16'h1041, "R11 new rate after wrap", count, 16'h1041);
    svc = 1;
    cyc();
    svc = 0;
    cycn(384);
    chk(count == 16'h1003, "R3 slow rate", count, 16'h1003);
    win_bound = 8'h20; svc = 1;
    cyc();
    svc = 0;
    chk(nmi && timeout_flag, "R5 premature nmi", {nmi, timeout_flag}, 2'b11);
    chk(count[15:8] == 8'h10, "R5 no reload", count[15:8], 8'h10);
    cyc();
    chk(!nmi && timeout_flag, "R12 nmi single cycle", {nmi, timeout_flag}, 2'b01);
    rst = 1;
    cycn(2);
    rst = 0;
    chk(!timeout_flag, "R1 flag cleared by reset", timeout_flag, 0);
    // Overflow, prewarning and reset request at the fast rate
    slow_sel = 0; win_bound = 8'h00; reload_val = 8'hFF; svc = 1;
    cyc();
    svc = 0;
    cycn(511);
    chk(!nmi, "R6 no nmi before wrap", nmi, 0);
    cyc();
    chk(nmi && count == 16'h0, "R6 wrap raises nmi", {nmi, count}, 17'h10000);
    cyc();
    chk(!nmi, "R12 nmi drops", nmi, 0);
    svc = 1;
    cyc();
    svc = 0;
    chk(count[15:8] == 8'h00 && timeout_flag, "R8 service ignored", {count[15:8], timeout_flag}, 9'h001);
    cycn(125);
    chk(!rst_req, "R7 no early reset request", rst_req, 0);
    cyc();
    chk(rst_req && count == 16'h0 && !timeout_flag, "R7 reset request", {rst_req, count, timeout_flag}, 18'h20000);
    cyc();
    chk(!rst_req, "R7 single-cycle request", rst_req, 0);
    // Constrained random phase
    for (int i = 0; i < 20000; i++) begin
      r = $urandom;
      svc = (r[5:0] == 6'd0);
      if (r[10:6] == 5'd0) en = ~en;
      if (r[14:11] == 4'd0) dbg_hold = ~dbg_hold;
      if (r[22:15] == 8'd0) slow_sel = ~slow_sel;
      if (r[26:23] == 4'd0) win_bound = 8'($urandom_range(0, 255));
      if (r[30:27] == 4'd0) reload_val = 8'($urandom_range(192, 255));
      if (!en && r[31]) en = 1;
      cyc();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule